// File: doc/BRIEF.md
# Framed NRZ Contactless Command Receiver

This block recovers reader-to-card command frames from a stream of one-bit amplitude samples, the kind produced by the envelope detector of a 13.56 MHz proximity card front end running the Type B air interface. Samples come in packed eight to a byte. The block unpacks them, first-received sample in the most significant bit, and consumes one sample per clock. It looks for the long low start-of-frame phase. It then locks onto the falling edge of each character's start bit and samples every bit in the middle of its period.

A character is a start bit, eight data bits sent least significant first, and a stop bit. Each good character shows up as a one-cycle strobe on the byte output. A character whose ten bits are all low closes the frame, and a one-cycle done pulse reports how many bytes were stored. Every framing fault sends the receiver straight back to the unsynchronised state, with no hold-off time. A reader-active flag shows when a frame is being received past its start-of-frame phase.

Top module: `nrz_cmd_rx`

## Requirements
- R1: On an `in_valid` cycle, `in_byte` is loaded and its eight samples are consumed one per clock, bit 7 first. A new byte may arrive at most once every 8 cycles.
- R2: A start-of-frame low run is accepted only if it covers at least SOF_MIN_BITS full bit periods (default 10 periods of SPB=4 samples, so 40 samples). A shorter low run that is followed by a high sample returns the receiver to unsynchronised.
- R3: A start-of-frame low run that reaches more than SOF_MAX_BITS whole bit periods (default 12, so the 52nd low sample) abandons the frame. A run of 51 low samples is still accepted.
- R4: `reader_active` is 1 only while the receiver waits for a start bit or receives a character. It stays 0 when idle and during the start-of-frame low phase.
- R5: While waiting for a start bit, the receiver drops to unsynchronised on the sample that makes the high-sample count exceed GAP_MAX (default 25). The count restarts at zero on the start-of-frame rising edge and at the middle of each stop bit.
- R6: A falling edge while waiting starts a character. Bit k is sampled SPB/2 + k*SPB samples after that edge. A character with a low start bit and a high stop bit produces one `byte_valid` cycle, and `byte_data` carries the data bits with the first one in bit 0.
- R7: A character whose ten samples are all 0 ends the frame. If at least one byte was stored, `frame_done` pulses for one cycle with `frame_len` equal to that count. If no byte was stored, nothing is reported.
- R8: A character that completes when MAX_BYTES bytes are already stored is not output, and the frame is dropped without a done pulse. A frame of exactly MAX_BYTES bytes completes normally.
- R9: A character with a low stop bit, or any other malformed character that is not all zeros, produces no byte. The frame is dropped with no done pulse.
- R10: An active-low asynchronous reset, released after two clocks, clears all outputs and state. Every new start-of-frame restarts the byte count at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Packed sample byte present |
| in_byte | input | 8 | Eight samples, bit 7 earliest |
| byte_valid | output | 1 | One-cycle strobe for a received data byte |
| byte_data | output | 8 | Received data byte |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| frame_len | output | CNT_W (clog2(MAX_BYTES+1), 9 by default) | Bytes in the finished frame |
| reader_active | output | 1 | Receiver is past the start-of-frame low phase |

## Verification
The checks rely on one assumption about the inputs: packed sample bytes arrive no closer together than eight clocks. If they came faster, the unpacker would overwrite samples it has not yet consumed, and the bit timing would be lost. The checker holds a counter of cycles since the last `in_valid` and flags any violation. The stimulus always drives `in_valid` for one cycle and then waits seven, so this rule is met. Every frame in the stimulus ends with a long high run, which returns the receiver to the unsynchronised state before the next case starts.

// File: rtl/nrz_cmd_rx_pkg.sv
package nrz_cmd_rx_pkg;
  localparam int DATA_BITS = 8;
  localparam int CHAR_BITS = DATA_BITS + 2;

  // Order matters: states above RX_SOF mean the reader is sending
  typedef enum logic [1:0] {
    RX_IDLE,
    RX_SOF,
    RX_WAIT,
    RX_DATA
  } rx_state_e;
endpackage

// File: rtl/nrz_sample_unpack.sv
module nrz_sample_unpack (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       bit_valid,
  output logic       bit_val
);
  logic [7:0] sreg_q, sreg_n;
  logic [3:0] left_q, left_n;

  always_comb begin
    sreg_n = sreg_q;
    left_n = left_q;
    if (in_valid) begin
      sreg_n = in_byte;
      left_n = 4'd8;
    end else if (left_q != 4'd0) begin
      sreg_n = {sreg_q[6:0], 1'b0};
      left_n = left_q - 4'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= 8'h00;
      left_q <= 4'd0;
    end else begin
      sreg_q <= sreg_n;
      left_q <= left_n;
    end
  end

  assign bit_valid = (left_q != 4'd0);
  assign bit_val   = sreg_q[7];
endmodule

// File: rtl/nrz_char_fsm.sv
module nrz_char_fsm
  import nrz_cmd_rx_pkg::*;
#(
  parameter int SPB          = 4,
  parameter int SOF_MIN_BITS = 10,
  parameter int SOF_MAX_BITS = 12,
  parameter int GAP_MAX      = 25,
  parameter int MAX_BYTES    = 256,
  parameter int CNT_W        = $clog2(MAX_BYTES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_valid,
  input  logic                 bit_val,
  output logic                 byte_valid,
  output logic [DATA_BITS-1:0] byte_data,
  output logic                 frame_done,
  output logic [CNT_W-1:0]     frame_len,
  output logic                 reader_active
);
  localparam int POS_LIM = (GAP_MAX > SPB) ? GAP_MAX : SPB;
  localparam int POS_W   = $clog2(POS_LIM + 2);
  localparam int BIT_LIM = (SOF_MAX_BITS > CHAR_BITS) ? SOF_MAX_BITS : CHAR_BITS;
  localparam int BIT_W   = $clog2(BIT_LIM + 2);

  localparam logic [POS_W-1:0] POS_ONE  = POS_W'(1);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(SPB - 1);
  localparam logic [POS_W-1:0] POS_MID  = POS_W'(SPB / 2);
  localparam logic [POS_W-1:0] GAP_LIM  = POS_W'(GAP_MAX);
  localparam logic [BIT_W-1:0] BIT_ONE  = BIT_W'(1);
  localparam logic [BIT_W-1:0] SOF_LO   = BIT_W'(SOF_MIN_BITS);
  localparam logic [BIT_W-1:0] SOF_HI   = BIT_W'(SOF_MAX_BITS);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(CHAR_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(MAX_BYTES);

  rx_state_e              state_q, state_n;
  logic [POS_W-1:0]       pos_q, pos_n, pos_step, pos_inc;
  logic [BIT_W-1:0]       bitc_q, bitc_n, bitc_inc;
  logic [CHAR_BITS-1:0]   shift_q, shift_n, shift_in;
  logic [CNT_W-1:0]       cnt_q, cnt_n;
  logic                   bv_n, fd_n;
  logic [DATA_BITS-1:0]   bd_n;
  logic [CNT_W-1:0]       fl_n;

  always_comb begin
    pos_inc  = pos_q + POS_ONE;
    pos_step = (pos_q == POS_LAST) ? '0 : pos_inc;
    bitc_inc = bitc_q + BIT_ONE;
    shift_in = {bit_val, shift_q[CHAR_BITS-1:1]};

    state_n = state_q;
    pos_n   = pos_q;
    bitc_n  = bitc_q;
    shift_n = shift_q;
    cnt_n   = cnt_q;
    bv_n    = 1'b0;
    bd_n    = byte_data;
    fd_n    = 1'b0;
    fl_n    = frame_len;

    if (bit_valid) begin
      unique case (state_q)
        RX_IDLE: begin
          if (!bit_val) begin
            state_n = RX_SOF;
            pos_n   = POS_ONE;
            bitc_n  = '0;
            cnt_n   = '0;
          end
        end
        RX_SOF: begin
          if (bit_val) begin
            if (bitc_q >= SOF_LO) begin
              state_n = RX_WAIT;
              pos_n   = '0;
            end else begin
              state_n = RX_IDLE;
            end
          end else if (pos_q == POS_LAST) begin
            pos_n  = '0;
            bitc_n = bitc_inc;
            if (bitc_inc > SOF_HI) state_n = RX_IDLE;
          end else begin
            pos_n = pos_inc;
          end
        end
        RX_WAIT: begin
          if (bit_val) begin
            if (pos_inc > GAP_LIM) state_n = RX_IDLE;
            else                   pos_n   = pos_inc;
          end else begin
            state_n = RX_DATA;
            pos_n   = '0;
            bitc_n  = '0;
            shift_n = '0;
          end
        end
        RX_DATA: begin
          pos_n = pos_step;
          if (pos_step == POS_MID) begin
            shift_n = shift_in;
            if (bitc_q == BIT_LAST) begin
              if (!shift_in[0] && shift_in[CHAR_BITS-1]) begin
                if (cnt_q >= CNT_MAX) begin
                  state_n = RX_IDLE;
                end else begin
                  bv_n    = 1'b1;
                  bd_n    = shift_in[DATA_BITS:1];
                  cnt_n   = cnt_q + CNT_ONE;
                  state_n = RX_WAIT;
                  pos_n   = '0;
                end
              end else if (shift_in == '0) begin
                state_n = RX_IDLE;
                if (cnt_q != '0) begin
                  fd_n = 1'b1;
                  fl_n = cnt_q;
                end
              end else begin
                state_n = RX_IDLE;
              end
            end else begin
              bitc_n = bitc_inc;
            end
          end
        end
        default: state_n = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= RX_IDLE;
      pos_q      <= '0;
      bitc_q     <= '0;
      shift_q    <= '0;
      cnt_q      <= '0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
      frame_done <= 1'b0;
      frame_len  <= '0;
    end else begin
      state_q    <= state_n;
      pos_q      <= pos_n;
      bitc_q     <= bitc_n;
      shift_q    <= shift_n;
      cnt_q      <= cnt_n;
      byte_valid <= bv_n;
      byte_data  <= bd_n;
      frame_done <= fd_n;
      frame_len  <= fl_n;
    end
  end

  assign reader_active = (state_q > RX_SOF);
endmodule

// File: rtl/nrz_cmd_rx.sv
module nrz_cmd_rx
  import nrz_cmd_rx_pkg::*;
#(
  parameter int SPB          = 4,
  parameter int SOF_MIN_BITS = 10,
  parameter int SOF_MAX_BITS = 12,
  parameter int GAP_MAX      = 25,
  parameter int MAX_BYTES    = 256,
  localparam int CNT_W       = $clog2(MAX_BYTES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [7:0]           in_byte,
  output logic                 byte_valid,
  output logic [DATA_BITS-1:0] byte_data,
  output logic                 frame_done,
  output logic [CNT_W-1:0]     frame_len,
  output logic                 reader_active
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  logic       bit_valid, bit_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  nrz_sample_unpack u_unpack (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .in_valid  (in_valid),
    .in_byte   (in_byte),
    .bit_valid (bit_valid),
    .bit_val   (bit_val)
  );

  nrz_char_fsm #(
    .SPB          (SPB),
    .SOF_MIN_BITS (SOF_MIN_BITS),
    .SOF_MAX_BITS (SOF_MAX_BITS),
    .GAP_MAX      (GAP_MAX),
    .MAX_BYTES    (MAX_BYTES),
    .CNT_W        (CNT_W)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_core_n),
    .bit_valid     (bit_valid),
    .bit_val       (bit_val),
    .byte_valid    (byte_valid),
    .byte_data     (byte_data),
    .frame_done    (frame_done),
    .frame_len     (frame_len),
    .reader_active (reader_active)
  );
endmodule

// File: rtl/nrz_cmd_rx_chk.sv
module nrz_cmd_rx_chk #(
  parameter int MAX_BYTES = 256,
  parameter int CNT_W     = $clog2(MAX_BYTES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             byte_valid,
  input logic             frame_done,
  input logic [CNT_W-1:0] frame_len,
  input logic             reader_active
);
  logic [2:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_q <= 3'd7;
    else if (in_valid)       since_q <= 3'd0;
    else if (since_q != 3'd7) since_q <= since_q + 3'd1;
  end

  AST_IN_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> since_q == 3'd7); // R1
  AST_BYTE_IN_RX: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> $past(reader_active)); // R4
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_valid && frame_done)); // R6
  AST_DONE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> frame_len != '0); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !reader_active && $past(reader_active)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> frame_len <= CNT_W'(MAX_BYTES)); // R8
endmodule

bind nrz_cmd_rx nrz_cmd_rx_chk #(
  .MAX_BYTES (MAX_BYTES),
  .CNT_W     (CNT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .byte_valid    (byte_valid),
  .frame_done    (frame_done),
  .frame_len     (frame_len),
  .reader_active (reader_active)
);

// File: tb/test_nrz_cmd_rx.sv
module test_nrz_cmd_rx;
  localparam int SPB    = 4;
  localparam int TB_MAX = 4;
  localparam int CW     = $clog2(TB_MAX + 1);

  typedef struct packed {
    logic [7:0] sof;
    logic [7:0] gap;
    logic [7:0] nb;
    logic [7:0] seed;
    logic       bad;
    logic [7:0] expb;
    logic       expd;
  } row_t;

  // sof, gap, bytes, seed, bad stop, expected bytes, expected done
  localparam row_t ROWS [10] = '{
    '{8'd44, 8'd8,  8'd3, 8'h5A, 1'b0, 8'd3, 1'b1},  // R6 R7 normal
    '{8'd40, 8'd12, 8'd2, 8'h01, 1'b0, 8'd2, 1'b1},  // R2 minimum SOF
    '{8'd39, 8'd8,  8'd2, 8'h33, 1'b0, 8'd0, 1'b0},  // R2 short SOF
    '{8'd51, 8'd24, 8'd1, 8'h80, 1'b0, 8'd1, 1'b1},  // R3 R5 limits met
    '{8'd52, 8'd8,  8'd2, 8'h44, 1'b0, 8'd0, 1'b0},  // R3 SOF too long
    '{8'd44, 8'd25, 8'd2, 8'hC3, 1'b0, 8'd1, 1'b0},  // R5 gap overrun
    '{8'd44, 8'd6,  8'd2, 8'h96, 1'b1, 8'd1, 1'b0},  // R9 bad stop
    '{8'd44, 8'd6,  8'd0, 8'h00, 1'b0, 8'd0, 1'b0},  // R7 empty frame
    '{8'd44, 8'd6,  8'd4, 8'h11, 1'b0, 8'd4, 1'b1},  // R8 exactly full
    '{8'd44, 8'd6,  8'd5, 8'h11, 1'b0, 8'd4, 1'b0}   // R8 overflow
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [7:0]    in_byte;
  logic          byte_valid;
  logic [7:0]    byte_data;
  logic          frame_done;
  logic [CW-1:0] frame_len;
  logic          reader_active;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic stream [0:2047];
  int   slen;
  logic [7:0] got_bytes [0:15];
  int   nb_got, nd_got, len_got;
  bit   act_seen;

  always #2.5 clk = ~clk;

  nrz_cmd_rx #(.SPB(SPB), .MAX_BYTES(TB_MAX)) i_nrz_cmd_rx (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_byte       (in_byte),
    .byte_valid    (byte_valid),
    .byte_data     (byte_data),
    .frame_done    (frame_done),
    .frame_len     (frame_len),
    .reader_active (reader_active)
  );

  always @(negedge clk) begin
    if (byte_valid) begin
      if (nb_got < 16) got_bytes[nb_got] = byte_data;
      nb_got++;
    end
    if (frame_done) begin
      nd_got++;
      len_got = int'(frame_len);
    end
    if (reader_active) act_seen = 1'b1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    nb_got = 0; nd_got = 0; len_got = 0; act_seen = 1'b0;
  endtask

  task automatic push(input logic v, input int n);
    for (int i = 0; i < n; i++) begin
      stream[slen] = v;
      slen++;
    end
  endtask

  task automatic push_char(input logic [7:0] d, input logic stop);
    push(1'b0, SPB);
    for (int i = 0; i < 8; i++) push(d[i], SPB);
    push(stop, SPB);
  endtask

  task automatic build(input row_t r);
    slen = 0;
    push(1'b1, 16);
    push(1'b0, int'(r.sof));
    push(1'b1, int'(r.gap) + 1);
    for (int k = 0; k < int'(r.nb); k++) begin
      push_char(r.seed + 8'(k * 8'h3B), !(r.bad && k == int'(r.nb) - 1));
      push(1'b1, int'(r.gap));
    end
    push(1'b0, 10 * SPB);
    push(1'b1, 40);
  endtask

  task automatic feed(input int nbytes_max);
    while (slen % 8 != 0) push(1'b1, 1);
    for (int b = 0; b < slen / 8 && b < nbytes_max; b++) begin
      @(negedge clk);
      in_valid = 1'b1;
      for (int i = 0; i < 8; i++) in_byte[7 - i] = stream[8 * b + i];
      @(negedge clk);
      in_valid = 1'b0;
      repeat (6) @(negedge clk);
    end
    repeat (20) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_row(input int idx, input row_t r);
    check(nb_got == int'(r.expb), $sformatf("R6 row%0d byte count", idx), nb_got, int'(r.expb));
    for (int k = 0; k < int'(r.expb) && k < nb_got; k++)  // R1 sample order, R6 LSB first
      check(got_bytes[k] == r.seed + 8'(k * 8'h3B), $sformatf("R6 row%0d byte%0d", idx, k),
            int'(got_bytes[k]), int'(r.seed + 8'(k * 8'h3B)));
    check(nd_got == int'(r.expd), $sformatf("R7 row%0d done count", idx), nd_got, int'(r.expd));
    if (r.expd) begin
      check(len_got == int'(r.nb), $sformatf("R7 row%0d frame_len", idx), len_got, int'(r.nb));
      check(act_seen, $sformatf("R4 row%0d reader_active seen", idx), int'(act_seen), 1);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_byte = 8'h00;
    clear_mon();
    repeat (3) @(negedge clk);
    // R10 reset state
    check(byte_valid == 1'b0 && frame_done == 1'b0, "R10 pulses in reset",
          int'({byte_valid, frame_done}), 0);
    check(reader_active == 1'b0, "R10 reader_active in reset", int'(reader_active), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < 10; i++) begin
      clear_mon();
      build(ROWS[i]);
      feed(1000);
      check_row(i, ROWS[i]);
      check(reader_active == 1'b0, $sformatf("R5 row%0d idle at end", i), int'(reader_active), 0);
    end

    // R4: long low run only, never active
    clear_mon();
    slen = 0;
    push(1'b1, 8); push(1'b0, 60); push(1'b1, 36);
    feed(1000);
    check(act_seen == 1'b0, "R4 inactive during SOF low", int'(act_seen), 0);
    check(nb_got == 0, "R3 no byte from low run", nb_got, 0);

    // R10: reset in mid-frame, then a fresh frame counts from zero
    clear_mon();
    build(ROWS[0]);
    feed(20);
    check(reader_active == 1'b1, "R4 active mid-frame", int'(reader_active), 1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(reader_active == 1'b0, "R10 reset clears active", int'(reader_active), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    clear_mon();
    build(ROWS[8]);
    feed(1000);
    check(nb_got == 4, "R10 bytes after reset", nb_got, 4);
    check(nd_got == 1 && len_got == 4, "R10 frame_len restarts", len_got, 4);

    do_reset();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule